// File: doc/BRIEF.md
# March-13N Memory Self-Test Engine

This block is a start-up self-test engine for a group of single-port SRAM instances. After a start request it takes control of every memory port and runs a thirteen-operations-per-word march test on each instance in turn. It then reports the result as a done flag and a pass flag. The test writes over the memory contents, so it belongs in the boot sequence before any functional use of the memories. A failed test never raises pass. The boot logic keys on done together with pass, so it stays halted.

The march runs as five elements, each applied to every word of an instance before the next element starts. The first element writes all-zero words in ascending order. The second, in ascending order, reads zero, writes ones, and reads ones at each word. The third, also ascending, reads ones, writes zeros, and reads zeros. The fourth and fifth repeat the second and third in descending address order. Every read is compared against an all-zero or all-one word. On the first mismatch the engine stops. It latches the instance index, the word address and the expected bit value, and keeps them readable on status outputs until the next start.

The memory ports are driven through a multiplexer. When the engine is idle or finished, the functional requests pass straight through. While a test is in progress, the functional requests are ignored.

Top module: `march_bist`

## Requirements
- R1: After reset, done, pass and fail_flag are low and fail_inst, fail_addr and fail_exp are zero.
- R2: A start sampled high while idle or finished launches a test. From the next cycle the engine issues exactly one memory operation per cycle. Each instance receives 13 x 2^ADDR_W operations in this element order: write 0; (read 0, write 1, read 1); (read 1, write 0, read 0); (read 0, write 1, read 1); (read 1, write 0, read 0). "0" means an all-zero word and "1" an all-one word.
- R3: The first three elements walk addresses upward from 0. The last two walk downward from 2^ADDR_W-1. Every operation of an element is finished at one address before the element moves to the next address.
- R4: Instances are tested one after another in ascending index order. The engine asserts only the chip select of the instance under test, and it asserts the write enable of that instance only for write operations.
- R5: Read data is taken one cycle after the read is issued, and it is compared against the expected all-zero or all-one word.
- R6: A test with no mismatch raises done and pass NUM_MEM x 13 x 2^ADDR_W + 1 cycles after the cycle in which start was sampled. fail_flag stays low.
- R7: On the first mismatch the engine stops. It raises done with pass low and fail_flag high, two cycles after the failing read was issued. It latches the instance index, the address and the expected bit of that read.
- R8: done, pass and the failure status hold until a new start. That start clears them in the cycle it is sampled.
- R9: From launch until done, the functional inputs and start have no effect on the memory ports. In the final compare cycle after the last operation, no chip select is asserted.
- R10: While the engine is idle or finished, each memory port carries the functional chip select, write enable, address and write data of its instance unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled while idle or finished |
| done | output | 1 | Test finished, held until the next launch |
| pass | output | 1 | Test finished with no mismatch |
| fail_flag | output | 1 | A mismatch was found |
| fail_inst | output | INST_W | Instance index of the first mismatch |
| fail_addr | output | ADDR_W | Word address of the first mismatch |
| fail_exp | output | 1 | Expected bit value of the failing read |
| func_cs | input | NUM_MEM | Functional chip select, one per instance |
| func_we | input | NUM_MEM | Functional write enable, one per instance |
| func_addr | input | NUM_MEM*ADDR_W | Functional address, one field per instance |
| func_wdata | input | NUM_MEM*DATA_W | Functional write data, one field per instance |
| mem_cs | output | NUM_MEM | Chip select to each memory |
| mem_we | output | NUM_MEM | Write enable to each memory |
| mem_addr | output | NUM_MEM*ADDR_W | Address to each memory |
| mem_wdata | output | NUM_MEM*DATA_W | Write data to each memory |
| mem_rdata | input | NUM_MEM*DATA_W | Read data from each memory, one cycle after the read |

## Verification
The cycle in which start is sampled is counted as cycle 0. Operation k of the whole run is then due on the memory ports in cycle k. The bench samples the ports at the falling edge of every cycle and compares them with the operation its own sequence function gives for that index. It keeps driving random functional traffic and random start pulses the whole time. done is due in cycle NUM_MEM x 13 x 2^ADDR_W + 1 for a clean run. For a run with a stuck bit injected into the bench memory model, done is due in cycle j + 2, where j is the index of the first read that sees the stuck bit. The bench computes j from the fault position before the run. It requires done to stay low in every earlier cycle and to be high in exactly that cycle. Pass-through is checked combinationally one time unit after the functional inputs change.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } bist_state_e;

   localparam logic [2:0] LAST_ELEM = 3'd4;

   // elements 3 and 4 walk the address space downward
   function automatic logic elem_desc(input logic [2:0] e);
      return (e >= 3'd3);
   endfunction

   // element 0 is a single write per word, the others have three steps
   function automatic logic [1:0] elem_last_step(input logic [2:0] e);
      return (e == 3'd0) ? 2'd0 : 2'd2;
   endfunction

   function automatic logic step_write(input logic [2:0] e, input logic [1:0] s);
      return (e == 3'd0) ? 1'b1 : (s == 2'd1);
   endfunction

   // data bit written, or expected on a read, for element e and step s
   function automatic logic step_data(input logic [2:0] e, input logic [1:0] s);
      logic v;
      if (e == 3'd0)     v = 1'b0;
      else if (e[0])     v = (s != 2'd0);
      else               v = (s == 2'd0);
      return v;
   endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
   import march_bist_pkg::*;
#(
   parameter int unsigned NUM_MEM = 3,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned INST_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              adv,
   output logic [INST_W-1:0] inst,
   output logic [2:0]        elem,
   output logic [1:0]        step,
   output logic [ADDR_W-1:0] addr,
   output logic              last_op
);
   localparam logic [ADDR_W-1:0] ADDR_MAX  = {ADDR_W{1'b1}};
   localparam logic [INST_W-1:0] INST_LAST = INST_W'(NUM_MEM - 1);

   logic [INST_W-1:0] inst_q;
   logic [2:0]        elem_q;
   logic [1:0]        step_q;
   logic [ADDR_W-1:0] addr_q;
   logic              desc;
   logic              step_end;
   logic              addr_end;
   logic [2:0]        elem_nx;

   assign desc     = elem_desc(elem_q);
   assign step_end = (step_q == elem_last_step(elem_q));
   assign addr_end = desc ? (addr_q == '0) : (addr_q == ADDR_MAX);
   assign elem_nx  = elem_q + 3'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inst_q <= '0;
         elem_q <= '0;
         step_q <= '0;
         addr_q <= '0;
      end else if (init) begin
         inst_q <= '0;
         elem_q <= '0;
         step_q <= '0;
         addr_q <= '0;
      end else if (adv) begin
         if (!step_end) begin
            step_q <= step_q + 2'd1;
         end else begin
            step_q <= '0;
            if (!addr_end) begin
               addr_q <= desc ? (addr_q - ADDR_W'(1)) : (addr_q + ADDR_W'(1));
            end else if (elem_q != LAST_ELEM) begin
               elem_q <= elem_nx;
               addr_q <= elem_desc(elem_nx) ? ADDR_MAX : '0;
            end else if (inst_q != INST_LAST) begin
               elem_q <= '0;
               addr_q <= '0;
               inst_q <= inst_q + INST_W'(1);
            end
         end
      end
   end

   assign inst    = inst_q;
   assign elem    = elem_q;
   assign step    = step_q;
   assign addr    = addr_q;
   assign last_op = (inst_q == INST_LAST) && (elem_q == LAST_ELEM) && step_end && addr_end;

   assert_addr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !init && step_end && !addr_end && !desc |=> addr_q == $past(addr_q) + ADDR_W'(1));

   assert_addr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !init && step_end && !addr_end && desc |=> addr_q == $past(addr_q) - ADDR_W'(1));

   assert_inst_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !init |=> (inst_q == $past(inst_q)) || (inst_q == $past(inst_q) + INST_W'(1)));

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
   parameter int unsigned NUM_MEM = 3,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned INST_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      issue_rd,
   input  logic                      exp_bit,
   input  logic [ADDR_W-1:0]         rd_addr,
   input  logic [INST_W-1:0]         rd_inst,
   input  logic [NUM_MEM*DATA_W-1:0] mem_rdata,
   output logic                      mismatch,
   output logic                      failed,
   output logic [INST_W-1:0]         fail_inst,
   output logic [ADDR_W-1:0]         fail_addr,
   output logic                      fail_exp
);
   logic              vld_q;
   logic              exp_q;
   logic [ADDR_W-1:0] addr_q;
   logic [INST_W-1:0] inst_q;
   logic [DATA_W-1:0] rd_word;
   logic              failed_q;
   logic [INST_W-1:0] f_inst_q;
   logic [ADDR_W-1:0] f_addr_q;
   logic              f_exp_q;

   // read tag travels one cycle alongside the memory access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         exp_q  <= 1'b0;
         addr_q <= '0;
         inst_q <= '0;
      end else begin
         vld_q  <= issue_rd && !clear;
         exp_q  <= exp_bit;
         addr_q <= rd_addr;
         inst_q <= rd_inst;
      end
   end

   assign rd_word  = mem_rdata[DATA_W*int'(inst_q) +: DATA_W];
   assign mismatch = vld_q && (rd_word != {DATA_W{exp_q}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         failed_q <= 1'b0;
         f_inst_q <= '0;
         f_addr_q <= '0;
         f_exp_q  <= 1'b0;
      end else if (clear) begin
         failed_q <= 1'b0;
         f_inst_q <= '0;
         f_addr_q <= '0;
         f_exp_q  <= 1'b0;
      end else if (mismatch && !failed_q) begin
         failed_q <= 1'b1;
         f_inst_q <= inst_q;
         f_addr_q <= addr_q;
         f_exp_q  <= exp_q;
      end
   end

   assign failed    = failed_q;
   assign fail_inst = f_inst_q;
   assign fail_addr = f_addr_q;
   assign fail_exp  = f_exp_q;

   assert_first_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      failed_q && !clear |=> failed_q && $stable(f_addr_q) && $stable(f_inst_q) && $stable(f_exp_q));

   assert_compare_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |-> $past(issue_rd));

endmodule

// File: rtl/mbist_mux.sv
module mbist_mux #(
   parameter int unsigned NUM_MEM = 3,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned INST_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      busy,
   input  logic                      issue,
   input  logic [INST_W-1:0]         eng_inst,
   input  logic                      eng_we,
   input  logic [ADDR_W-1:0]         eng_addr,
   input  logic                      eng_data,
   input  logic [NUM_MEM-1:0]        func_cs,
   input  logic [NUM_MEM-1:0]        func_we,
   input  logic [NUM_MEM*ADDR_W-1:0] func_addr,
   input  logic [NUM_MEM*DATA_W-1:0] func_wdata,
   output logic [NUM_MEM-1:0]        mem_cs,
   output logic [NUM_MEM-1:0]        mem_we,
   output logic [NUM_MEM*ADDR_W-1:0] mem_addr,
   output logic [NUM_MEM*DATA_W-1:0] mem_wdata
);
   for (genvar i = 0; i < NUM_MEM; i++) begin : g_port
      logic hit;
      assign hit = issue && (eng_inst == INST_W'(i));
      assign mem_cs[i] = busy ? hit : func_cs[i];
      assign mem_we[i] = busy ? (hit && eng_we) : func_we[i];
      assign mem_addr[i*ADDR_W +: ADDR_W] =
         busy ? eng_addr : func_addr[i*ADDR_W +: ADDR_W];
      assign mem_wdata[i*DATA_W +: DATA_W] =
         busy ? {DATA_W{eng_data}} : func_wdata[i*DATA_W +: DATA_W];
   end

   assert_single_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $onehot0(mem_cs));

   assert_we_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((mem_we & ~mem_cs) == '0));

endmodule

// File: rtl/march_bist.sv
module march_bist
   import march_bist_pkg::*;
#(
   parameter int unsigned NUM_MEM = 3,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned INST_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic                      done,
   output logic                      pass,
   output logic                      fail_flag,
   output logic [INST_W-1:0]         fail_inst,
   output logic [ADDR_W-1:0]         fail_addr,
   output logic                      fail_exp,
   input  logic [NUM_MEM-1:0]        func_cs,
   input  logic [NUM_MEM-1:0]        func_we,
   input  logic [NUM_MEM*ADDR_W-1:0] func_addr,
   input  logic [NUM_MEM*DATA_W-1:0] func_wdata,
   output logic [NUM_MEM-1:0]        mem_cs,
   output logic [NUM_MEM-1:0]        mem_we,
   output logic [NUM_MEM*ADDR_W-1:0] mem_addr,
   output logic [NUM_MEM*DATA_W-1:0] mem_wdata,
   input  logic [NUM_MEM*DATA_W-1:0] mem_rdata
);
   if (NUM_MEM < 1) begin : g_bad_num
      $error("march_bist: NUM_MEM must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("march_bist: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("march_bist: DATA_W must be at least 1");
   end

   bist_state_e       state_q;
   logic              pass_q;
   logic              launch;
   logic              run;
   logic              busy;
   logic [INST_W-1:0] s_inst;
   logic [2:0]        s_elem;
   logic [1:0]        s_step;
   logic [ADDR_W-1:0] s_addr;
   logic              s_last;
   logic              op_we;
   logic              op_data;
   logic              mismatch;

   assign launch  = start && (state_q == ST_IDLE || state_q == ST_DONE);
   assign run     = (state_q == ST_RUN);
   assign busy    = run || (state_q == ST_DRAIN);
   assign op_we   = step_write(s_elem, s_step);
   assign op_data = step_data(s_elem, s_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) state_q <= ST_RUN;
            ST_RUN: begin
               if (mismatch)    state_q <= ST_DONE;
               else if (s_last) state_q <= ST_DRAIN;
            end
            ST_DRAIN: begin
               state_q <= ST_DONE;
               pass_q  <= !mismatch;
            end
            ST_DONE: if (start) state_q <= ST_RUN;
            default: state_q <= ST_IDLE;
         endcase
         if (launch) pass_q <= 1'b0;
      end
   end

   mbist_seq #(.NUM_MEM(NUM_MEM), .ADDR_W(ADDR_W), .INST_W(INST_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (launch),
      .adv     (run),
      .inst    (s_inst),
      .elem    (s_elem),
      .step    (s_step),
      .addr    (s_addr),
      .last_op (s_last)
   );

   mbist_cmp #(.NUM_MEM(NUM_MEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INST_W(INST_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .issue_rd  (run && !op_we),
      .exp_bit   (op_data),
      .rd_addr   (s_addr),
      .rd_inst   (s_inst),
      .mem_rdata (mem_rdata),
      .mismatch  (mismatch),
      .failed    (fail_flag),
      .fail_inst (fail_inst),
      .fail_addr (fail_addr),
      .fail_exp  (fail_exp)
   );

   mbist_mux #(.NUM_MEM(NUM_MEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INST_W(INST_W)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .issue      (run),
      .eng_inst   (s_inst),
      .eng_we     (op_we),
      .eng_addr   (s_addr),
      .eng_data   (op_data),
      .func_cs    (func_cs),
      .func_we    (func_we),
      .func_addr  (func_addr),
      .func_wdata (func_wdata),
      .mem_cs     (mem_cs),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata)
   );

   assign done = (state_q == ST_DONE);
   assign pass = pass_q;

   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && $stable(pass) && $stable(fail_flag));

   assert_stop_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mismatch |=> done && !pass && fail_flag);

   assert_pass_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> done && !fail_flag && ($past(state_q) == ST_DRAIN));

   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run && !mismatch && !s_last |=> run);

endmodule

// File: tb/tb_march_bist.sv
`timescale 1ns/1ps
module tb_march_bist;
   localparam int NUM_MEM = 3;
   localparam int ADDR_W  = 4;
   localparam int DATA_W  = 8;
   localparam int INST_W  = 2;
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int OPS_PER = 13 * DEPTH;
   localparam int T_OPS   = NUM_MEM * OPS_PER;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, pass, fail_flag, fail_exp;
   logic [INST_W-1:0] fail_inst;
   logic [ADDR_W-1:0] fail_addr;
   logic [NUM_MEM-1:0] func_cs = '0, func_we = '0;
   logic [NUM_MEM*ADDR_W-1:0] func_addr = '0;
   logic [NUM_MEM*DATA_W-1:0] func_wdata = '0;
   logic [NUM_MEM-1:0] mem_cs, mem_we;
   logic [NUM_MEM*ADDR_W-1:0] mem_addr;
   logic [NUM_MEM*DATA_W-1:0] mem_wdata;
   logic [NUM_MEM*DATA_W-1:0] mem_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   march_bist #(.NUM_MEM(NUM_MEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
      .fail_flag(fail_flag), .fail_inst(fail_inst), .fail_addr(fail_addr),
      .fail_exp(fail_exp), .func_cs(func_cs), .func_we(func_we),
      .func_addr(func_addr), .func_wdata(func_wdata), .mem_cs(mem_cs),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   // memory model with an optional stuck bit seen on reads
   logic [DATA_W-1:0] store [NUM_MEM][DEPTH];
   bit f_en = 0;
   int f_inst = 0, f_addr = 0, f_bit = 0;
   bit f_val = 0;

   always @(posedge clk) begin
      for (int i = 0; i < NUM_MEM; i++) begin
         if (mem_cs[i]) begin
            if (mem_we[i]) begin
               store[i][mem_addr[i*ADDR_W +: ADDR_W]] <= mem_wdata[i*DATA_W +: DATA_W];
            end else begin
               logic [DATA_W-1:0] w;
               w = store[i][mem_addr[i*ADDR_W +: ADDR_W]];
               if (f_en && i == f_inst && int'(mem_addr[i*ADDR_W +: ADDR_W]) == f_addr)
                  w[f_bit] = f_val;
               mem_rdata[i*DATA_W +: DATA_W] <= w;
            end
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // operation j of a full run, derived from the march definition
   function automatic void op_at(input int j, output int inst, output int addr,
                                 output bit we, output bit d);
      int r, e, w, s, ai;
      inst = j / OPS_PER;
      r = j % OPS_PER;
      if (r < DEPTH) begin
         addr = r; we = 1; d = 0;
      end else begin
         r  = r - DEPTH;
         e  = 1 + r / (3 * DEPTH);
         w  = r % (3 * DEPTH);
         ai = w / 3;
         s  = w % 3;
         addr = (e >= 3) ? DEPTH - 1 - ai : ai;
         we = (s == 1);
         if (e == 1 || e == 3) d = (s != 0);
         else                  d = (s == 0);
      end
   endfunction

   task automatic drive_func_random();
      func_cs    = NUM_MEM'($urandom());
      func_we    = NUM_MEM'($urandom());
      func_addr  = (NUM_MEM*ADDR_W)'($urandom());
      func_wdata = (NUM_MEM*DATA_W)'({$urandom(), $urandom()});
   endtask

   task automatic check_passthru(input string req);
      drive_func_random();
      #1;
      chk(req, {mem_cs, mem_we, mem_addr, mem_wdata},
          {func_cs, func_we, func_addr, func_wdata}, "functional pass-through");
   endtask

   task automatic run_test(input bit en, input int fi, input int fa, input int fb, input bit fv);
      int exp_j, due, oi, oa;
      bit owe, od;
      f_en = en; f_inst = fi; f_addr = fa; f_bit = fb; f_val = fv;
      exp_j = -1;
      if (en) begin
         for (int j = 0; j < T_OPS; j++) begin
            op_at(j, oi, oa, owe, od);
            if (!owe && oi == fi && oa == fa && od != fv) begin
               exp_j = j;
               break;
            end
         end
      end
      due = (exp_j < 0) ? T_OPS + 1 : exp_j + 2;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      for (int c = 0; c <= due; c++) begin
         @(negedge clk);
         if (c == 0)  // R8: launch clears the previous result
            chk("R8", {done, pass, fail_flag}, 3'b000, "cleared on launch");
         if (c < due) begin
            if (done) begin
               chk("R6/R7", 1, 0, $sformatf("done early in cycle %0d", c));
               break;
            end
            if (c < T_OPS) begin
               logic [NUM_MEM-1:0] ecs, ewe;
               op_at(c, oi, oa, owe, od);
               ecs = NUM_MEM'(1) << oi;
               ewe = owe ? ecs : '0;
               // R2 R3 R4 R9: engine operation on the ports, functional traffic ignored
               chk("R2", {mem_cs, mem_we, mem_addr[oi*ADDR_W +: ADDR_W],
                          mem_wdata[oi*DATA_W +: DATA_W]},
                   {ecs, ewe, ADDR_W'(oa), od ? {DATA_W{1'b1}} : {DATA_W{1'b0}}},
                   $sformatf("op %0d", c));
            end else begin
               chk("R9", mem_cs, '0, "no select in final compare cycle");
            end
            drive_func_random();
            start = ($urandom() % 8) == 0;
         end else begin
            start = 1'b0;
            if (exp_j < 0) begin
               chk("R6", {done, pass, fail_flag}, 3'b110, "clean result timing");
            end else begin
               op_at(exp_j, oi, oa, owe, od);
               chk("R7", {done, pass, fail_flag}, 3'b101, "failure result timing");
               chk("R7", {fail_inst, fail_addr, fail_exp},
                   {INST_W'(oi), ADDR_W'(oa), od}, "captured failure");
            end
         end
      end
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R8", {done, pass}, {1'b1, exp_j < 0}, "result held");
         check_passthru("R10");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", {done, pass, fail_flag, fail_inst, fail_addr, fail_exp}, '0, "reset values");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {done, pass, fail_flag}, 3'b000, "idle after reset");
      check_passthru("R10");
      check_passthru("R10");

      run_test(0, 0, 0, 0, 0);                 // clean run, R6
      run_test(1, 0, 0, 0, 1'b1);              // first word, first instance, R7
      run_test(1, NUM_MEM-1, 0, DATA_W-1, 1'b0);
      run_test(1, 1, DEPTH-1, 3, 1'b1);        // top word, R3 boundary
      run_test(0, 0, 0, 0, 0);                 // restart after failure, R8
      for (int n = 0; n < 6; n++)
         run_test(1, int'($urandom() % NUM_MEM), int'($urandom() % DEPTH),
                  int'($urandom() % DATA_W), bit'($urandom() % 2));
      run_test(0, 0, 0, 0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule